// File: doc/BRIEF.md
# Low-Power Snoop State Controller

This block is the state sequencer that follows a processor core through its idle power states and lets the core answer bus snoops without losing track of the idle state it was in. Request strobes move the core from normal running into one of three idle states: stop-grant, halt power-down, or enhanced-halt power-down when the enhanced mode is enabled. A wake strobe brings it back to running.

When a snoop starts while the core is idle, the controller moves into a snoop-servicing state. It records which idle state it left in a small return register. It stays in the snoop state until the snoop is reported serviced, whichever bus agent serviced it, and then goes back to the recorded idle state. A snoop that starts in enhanced-halt power-down uses a separate enhanced snoop state. During the whole visit, a hold output keeps the reduced bus ratio and voltage code frozen. Snoop lookup, response data and clock gating belong to other blocks.

Top module: `lpsnp_ctrl`

## Requirements
- R1: Reset (active-low `rst_n`) puts the machine in the running state (code 0) with `snoop_active_o` and `hold_op_o` low.
- R2: From running, `stpgnt_req` leads to stop-grant (code 1) and takes priority over `halt_req`. Otherwise `halt_req` leads to halt power-down (code 2) when `ehalt_en` is 0, or to enhanced-halt power-down (code 3) when it is 1. Each move is seen one clock after the request.
- R3: `snp_start` in stop-grant or halt power-down leads to the snoop state (code 4) on the next clock, with `snoop_active_o` high.
- R4: `snp_start` in enhanced-halt power-down leads to the enhanced snoop state (code 5) on the next clock, with `snoop_active_o` high.
- R5: The snoop states are held until `snp_done` is seen. `wake` has no effect while a snoop is active.
- R6: The clock after `snp_done` is seen in a snoop state, the machine is back in the idle state it left before the snoop.
- R7: `hold_op_o` is high exactly in enhanced-halt power-down (code 3) and the enhanced snoop state (code 5).
- R8: `snp_start` and `snp_done` in the same cycle in an idle state give exactly one cycle in the snoop state, followed by the return to that idle state.
- R9: `snp_start` and `snp_done` in the running state are ignored, and the state stays at code 0.
- R10: `wake` in an idle state returns the machine to running (code 0). If `snp_start` arrives in the same cycle, the snoop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stpgnt_req | input | 1 | Request to enter stop-grant |
| halt_req | input | 1 | Request to enter halt power-down |
| ehalt_en | input | 1 | Selects the enhanced halt variant |
| snp_start | input | 1 | A bus snoop begins |
| snp_done | input | 1 | The snoop is serviced, by any agent |
| wake | input | 1 | Exit strobe from idle to running |
| state_o | output | 3 | Encoded current state |
| snoop_active_o | output | 1 | High in either snoop state |
| hold_op_o | output | 1 | Freezes bus ratio and voltage code |

## Verification
The assertions check on every cycle that:
- a snoop in stop-grant or halt enters the plain snoop state, and one in enhanced halt enters the enhanced snoop state;
- an active snoop holds until it is serviced;
- the return lands on the recorded origin;
- the hold output follows the enhanced states;
- requests other than the state-entry strobes leave the running state unchanged;
- a same-cycle start and finish gives a single-cycle visit.

Only the bench's scenarios can show:
- the request priority from running;
- snoop priority over wake;
- that wake is ignored mid-snoop;
- that reset in the middle of a snoop lands cleanly in running.

// File: rtl/lpsnp_pkg.sv
package lpsnp_pkg;
    localparam int ST_W  = 3;
    localparam int RET_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_RUN    = 3'd0,
        ST_STPGNT = 3'd1,
        ST_HALT   = 3'd2,
        ST_EHALT  = 3'd3,
        ST_SNP    = 3'd4,
        ST_ESNP   = 3'd5
    } state_e;

    typedef struct packed {
        state_e           st;
        logic [RET_W-1:0] ret;
        logic             pend;
    } ctl_t;
endpackage

// File: rtl/lpsnp_next.sv
module lpsnp_next
    import lpsnp_pkg::*;
(
    input  ctl_t ctl_q,
    input  logic stpgnt_req,
    input  logic halt_req,
    input  logic ehalt_en,
    input  logic snp_start,
    input  logic snp_done,
    input  logic wake,
    output ctl_t ctl_d
);
    logic idle_w;
    assign idle_w = (ctl_q.st == ST_STPGNT) || (ctl_q.st == ST_HALT) ||
                    (ctl_q.st == ST_EHALT);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_RUN: begin
                ctl_d.pend = 1'b0;
                if (stpgnt_req)
                    ctl_d.st = ST_STPGNT;
                else if (halt_req)
                    ctl_d.st = ehalt_en ? ST_EHALT : ST_HALT;
            end
            ST_STPGNT, ST_HALT, ST_EHALT: begin
                if (snp_start) begin
                    ctl_d.ret  = ctl_q.st[RET_W-1:0];
                    ctl_d.pend = snp_done;
                    ctl_d.st   = (ctl_q.st == ST_EHALT) ? ST_ESNP : ST_SNP;
                end else if (wake) begin
                    ctl_d.st = ST_RUN;
                end
            end
            ST_SNP, ST_ESNP: begin
                if (snp_done || ctl_q.pend) begin
                    ctl_d.pend = 1'b0;
                    ctl_d.st   = state_e'({1'b0, ctl_q.ret});
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase
        if (!idle_w && ctl_q.st != ST_SNP && ctl_q.st != ST_ESNP &&
            ctl_q.st != ST_RUN)
            ctl_d.st = ST_RUN;
    end
endmodule

// File: rtl/lpsnp_outdec.sv
module lpsnp_outdec
    import lpsnp_pkg::*;
(
    input  state_e          st,
    output logic [ST_W-1:0] state_o,
    output logic            snoop_active_o,
    output logic            hold_op_o
);
    always_comb begin
        state_o        = st;
        snoop_active_o = (st == ST_SNP) || (st == ST_ESNP);
        hold_op_o      = (st == ST_EHALT) || (st == ST_ESNP);
    end
endmodule

// File: rtl/lpsnp_ctrl.sv
module lpsnp_ctrl
    import lpsnp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stpgnt_req,
    input  logic            halt_req,
    input  logic            ehalt_en,
    input  logic            snp_start,
    input  logic            snp_done,
    input  logic            wake,
    output logic [ST_W-1:0] state_o,
    output logic            snoop_active_o,
    output logic            hold_op_o
);
    ctl_t ctl_d, ctl_q;

    lpsnp_next u_next (
        .ctl_q      (ctl_q),
        .stpgnt_req (stpgnt_req),
        .halt_req   (halt_req),
        .ehalt_en   (ehalt_en),
        .snp_start  (snp_start),
        .snp_done   (snp_done),
        .wake       (wake),
        .ctl_d      (ctl_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_RUN;
            ctl_q.ret  <= '0;
            ctl_q.pend <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lpsnp_outdec u_out (
        .st             (ctl_q.st),
        .state_o        (state_o),
        .snoop_active_o (snoop_active_o),
        .hold_op_o      (hold_op_o)
    );
endmodule

// File: rtl/lpsnp_chk.sv
module lpsnp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stpgnt_req,
    input logic       halt_req,
    input logic       snp_start,
    input logic       snp_done,
    input logic [2:0] state_o,
    input logic       snoop_active_o,
    input logic       hold_op_o
);
    logic [2:0] org_q;
    logic       idle_w;
    assign idle_w = (state_o == 3'd1) || (state_o == 3'd2) || (state_o == 3'd3);

    always_ff @(posedge clk) begin
        if (!rst_n)
            org_q <= 3'd0;
        else if (idle_w && snp_start)
            org_q <= state_o;
    end

    p_snp_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd1 || state_o == 3'd2) && snp_start) |=> state_o == 3'd4);

    p_esnp_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && snp_start) |=> (state_o == 3'd5 && snoop_active_o));

    p_snp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_active_o && $past(snoop_active_o) && !snp_done) |=> snoop_active_o);

    p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_active_o && snp_done) |=> state_o == org_q);

    p_hold_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_op_o == (state_o == 3'd3 || state_o == 3'd5));

    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && snp_start && snp_done) |=> ##1 !snoop_active_o);

    p_run_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !stpgnt_req && !halt_req) |=> state_o == 3'd0);
endmodule

bind lpsnp_ctrl lpsnp_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stpgnt_req     (stpgnt_req),
    .halt_req       (halt_req),
    .snp_start      (snp_start),
    .snp_done       (snp_done),
    .state_o        (state_o),
    .snoop_active_o (snoop_active_o),
    .hold_op_o      (hold_op_o)
);

// File: tb/lpsnp_ctrl_tb.sv
module lpsnp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stpgnt_req = 0, halt_req = 0, ehalt_en = 0;
    logic snp_start = 0, snp_done = 0, wake = 0;
    logic [2:0] state_o;
    logic snoop_active_o, hold_op_o;
    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpsnp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .stpgnt_req(stpgnt_req), .halt_req(halt_req),
        .ehalt_en(ehalt_en), .snp_start(snp_start), .snp_done(snp_done),
        .wake(wake), .state_o(state_o), .snoop_active_o(snoop_active_o),
        .hold_op_o(hold_op_o)
    );

    // inputs {stpgnt, halt, ehalt_en, start, done, wake}, expected state after edge
    localparam logic [8:0] VEC [NVEC] = '{
        {6'b000000, 3'd0},  // idle run
        {6'b000110, 3'd0},  // R9 snoop in run ignored
        {6'b100000, 3'd1},  // R2 stop-grant
        {6'b000100, 3'd4},  // R3 snoop from stop-grant
        {6'b000001, 3'd4},  // R5 wake ignored
        {6'b000000, 3'd4},  // R5 held
        {6'b000010, 3'd1},  // R6 return to stop-grant
        {6'b000001, 3'd0},  // R10 wake
        {6'b010000, 3'd2},  // R2 halt
        {6'b000100, 3'd4},  // R3 snoop from halt
        {6'b000010, 3'd2},  // R6 return to halt
        {6'b000110, 3'd4},  // R8 same-cycle start/done
        {6'b000000, 3'd2},  // R8 back after one cycle
        {6'b000001, 3'd0},  // R10 wake
        {6'b011000, 3'd3},  // R2 enhanced halt
        {6'b000100, 3'd5},  // R4 enhanced snoop
        {6'b000010, 3'd3},  // R6 back to enhanced halt
        {6'b000101, 3'd5},  // R10 snoop beats wake
        {6'b000010, 3'd3},  // R6
        {6'b000001, 3'd0},  // R10
        {6'b110000, 3'd1},  // R2 stop-grant priority
        {6'b000001, 3'd0}   // R10
    };

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        @(negedge clk);
        {stpgnt_req, halt_req, ehalt_en, snp_start, snp_done, wake} = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1;
                check("R1 state", state_o, 3'd0);
                check("R1 snoop_active", {2'b0, snoop_active_o}, 3'd0);
                check("R1 hold", {2'b0, hold_op_o}, 3'd0);
                @(negedge clk);
                rst_n = 1'b1;
                for (int i = 0; i < NVEC; i++) begin
                    logic [2:0] e;
                    e = VEC[i][2:0];
                    drive(VEC[i][8:3]);
                    check($sformatf("vector %0d state", i), state_o, e);
                    check("R3/R4 snoop_active", {2'b0, snoop_active_o},
                          {2'b0, (e == 3'd4 || e == 3'd5)});
                    check("R7 hold", {2'b0, hold_op_o},
                          {2'b0, (e == 3'd3 || e == 3'd5)});
                end
                // R1: reset in the middle of an enhanced snoop
                drive(6'b011000);
                drive(6'b000100);
                check("R4 pre-reset", state_o, 3'd5);
                @(negedge clk);
                rst_n = 1'b0;
                {stpgnt_req, halt_req, ehalt_en, snp_start, snp_done, wake} = '0;
                @(posedge clk);
                #1;
                check("R1 reset mid-snoop", state_o, 3'd0);
                check("R1 hold after reset", {2'b0, hold_op_o}, 3'd0);
                @(negedge clk);
                rst_n = 1'b1;
                // R5: long snoop held over many cycles with wake asserted
                drive(6'b010000);
                drive(6'b000100);
                for (int k = 0; k < 5; k++) begin
                    drive(6'b000001);
                    check("R5 long hold", state_o, 3'd4);
                end
                drive(6'b000010);
                check("R6 long return", state_o, 3'd2);
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule